// File: doc/BRIEF.md
# Thread Block Dispatcher

This block launches a kernel grid onto a small array of multithreaded SIMD processors. A host-side agent hands it a grid descriptor (total thread count, threads per block, shared-memory bytes needed by each block) through a valid/ready handshake. The dispatcher then emits one block per cycle. Each emission carries an ascending block ID and the index of the processor that must run the block. Blocks are independent, so the only ordering is the one the dispatcher chooses.

Each processor owns a fixed pool of local shared memory. The dispatcher keeps a private copy of how much of each pool is free and how many blocks are resident there. It reserves a block's allocation at the moment the block is issued. It returns that allocation when the processor pulses its completion line, meaning that block's threads have all exited. A processor whose pool cannot cover the request, whose resident count is at its limit, or that is not ready this cycle is passed over. Selection uses a rotating pointer, so successive blocks spread across the array. When every block has been issued and every one has retired, the dispatcher reports the grid complete and returns to idle. It then accepts the next descriptor. The threads-per-block field must be nonzero.

Top module: `block_dispatcher`

## Requirements
- R1: After reset, grid_ready_o is 1, disp_valid_o is 0 and grid_done_o is 0.
- R2: A descriptor is accepted only while idle. From the cycle after acceptance until grid completion, grid_ready_o is 0, and a descriptor offered in that time changes neither the block count nor the block IDs of the running grid.
- R3: A grid yields ceil(total threads / threads per block) blocks. They are issued with IDs 0, 1, 2, … in order, at most one per cycle, with the first one able to appear in the cycle after acceptance.
- R4: The target is the first eligible processor found by scanning upward from a rotating pointer, with wrap-around. After a dispatch to processor p the pointer moves to p+1 (wrapping). The pointer is 0 after reset and is kept from one grid to the next.
- R5: A block is issued only to a processor whose proc_ready_i bit is 1 in that same cycle.
- R6: Each processor has SMEM_CAP bytes (default 524288). A processor whose free bytes (capacity minus the requests of its resident blocks) are below the grid's per-block request is skipped. When no processor qualifies, dispatch stalls.
- R7: A processor already holding MAX_RES resident blocks (default 8) is skipped.
- R8: A pulse on blk_done_i[p] retires one block on processor p. Its reservation becomes usable for dispatch from the next cycle. A pulse on a processor with no resident block is ignored and does not count toward grid completion.
- R9: grid_done_o is a single-cycle pulse. It appears in the cycle after the clock edge that sampled the last completion pulse, provided all blocks have been issued. In that same cycle grid_ready_o is 1 again.
- R10: When a processor receives a new block and retires one in the same cycle, both changes take effect and its free memory and resident count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grid_valid_i | input | 1 | Grid descriptor offered |
| grid_ready_o | output | 1 | Dispatcher idle, descriptor accepted on valid |
| grid_threads_i | input | THREAD_W | Total thread count of the grid |
| grid_blk_thr_i | input | BLK_THR_W | Threads per block (nonzero) |
| grid_smem_i | input | MEM_W | Shared-memory bytes per block |
| proc_ready_i | input | NUM_PROC | Processor can take a block this cycle |
| blk_done_i | input | NUM_PROC | One block on that processor has fully exited |
| disp_valid_o | output | 1 | A block is issued this cycle |
| disp_blk_id_o | output | THREAD_W | ID of the issued block |
| disp_proc_o | output | PROC_W | Processor that receives the block |
| grid_done_o | output | 1 | Whole grid issued and retired (one-cycle pulse) |

## Verification
A reservation and a release can land on the same processor in the same cycle. A grid with large per-block requests provokes this. Every pool fills up, one block is retired on one processor, and the bench then pulses that processor's completion line again in the very cycle it receives the next block. The result is judged at the ports by the cycle that follows. If both updates were applied, one more block goes to that processor at once. If either update were lost, the dispatcher would stall or over-commit. A second overlap, a stray completion pulse on an empty processor while others are busy, is judged by the cycle in which grid_done_o finally appears.

// File: rtl/blkd_pkg.sv
package blkd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } blkd_state_e;
endpackage

// File: rtl/blkd_smem_slot.sv
module blkd_smem_slot #(
  parameter int unsigned MEM_W   = 20,
  parameter int unsigned CAP     = 524288,
  parameter int unsigned MAX_RES = 8,
  parameter int unsigned RES_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             done_i,
  input  logic [MEM_W-1:0] req_i,
  output logic             fit_o,
  output logic             rel_o
);
  logic [MEM_W-1:0] free_q, free_d;
  logic [RES_W-1:0] res_q, res_d;

  assign rel_o = done_i && (res_q != '0);
  assign fit_o = (free_q >= req_i) && (res_q < RES_W'(MAX_RES));

  always_comb begin
    free_d = free_q;
    res_d  = res_q;
    if (alloc_i) begin
      free_d = free_d - req_i;
      res_d  = res_d + 1'b1;
    end
    if (rel_o) begin
      free_d = free_d + req_i;
      res_d  = res_d - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= MEM_W'(CAP);
      res_q  <= '0;
    end else begin
      free_q <= free_d;
      res_q  <= res_d;
    end
  end

  a_r6_free_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q <= MEM_W'(CAP));
  a_r7_res_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_q <= RES_W'(MAX_RES));
  a_r8_stray_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && res_q == '0 && !alloc_i) |=> (res_q == '0));
  a_r10_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && done_i && res_q != '0) |=> (free_q == $past(free_q) && res_q == $past(res_q)));
endmodule

// File: rtl/blkd_rr_pick.sv
module blkd_rr_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [IDX_W-1:0] ptr_i,
  input  logic [N-1:0]     elig_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    int s;
    valid_o = 1'b0;
    idx_o   = '0;
    // scan backwards so the lowest offset from ptr wins
    for (int k = N - 1; k >= 0; k--) begin
      s = int'(ptr_i) + k;
      if (s >= int'(N)) s = s - int'(N);
      if (elig_i[IDX_W'(s)]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(s);
      end
    end
  end
endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
  import blkd_pkg::*;
#(
  parameter int unsigned NUM_PROC  = 4,
  parameter int unsigned THREAD_W  = 16,
  parameter int unsigned BLK_THR_W = 11,
  parameter int unsigned SMEM_CAP  = 524288,
  parameter int unsigned MAX_RES   = 8,
  localparam int unsigned MEM_W    = $clog2(SMEM_CAP + 1),
  localparam int unsigned PROC_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 grid_valid_i,
  output logic                 grid_ready_o,
  input  logic [THREAD_W-1:0]  grid_threads_i,
  input  logic [BLK_THR_W-1:0] grid_blk_thr_i,
  input  logic [MEM_W-1:0]     grid_smem_i,
  input  logic [NUM_PROC-1:0]  proc_ready_i,
  input  logic [NUM_PROC-1:0]  blk_done_i,
  output logic                 disp_valid_o,
  output logic [THREAD_W-1:0]  disp_blk_id_o,
  output logic [PROC_W-1:0]    disp_proc_o,
  output logic                 grid_done_o
);
  localparam int unsigned RES_W = $clog2(MAX_RES + 1);
  localparam int unsigned OUT_W = $clog2(NUM_PROC * MAX_RES + 1);

  blkd_state_e state_q;
  logic [THREAD_W-1:0]  left_q, left_step, left_d;
  logic [BLK_THR_W-1:0] blk_thr_q;
  logic [MEM_W-1:0]     smem_q;
  logic [THREAD_W-1:0]  next_id_q;
  logic [OUT_W-1:0]     out_q, out_d, nrel;
  logic [PROC_W-1:0]    ptr_q, pick_idx;
  logic                 pick_v, done_q, accept, finish;
  logic [NUM_PROC-1:0]  fit, rel, elig, alloc;

  assign grid_ready_o = (state_q == ST_IDLE);
  assign accept       = grid_valid_i && grid_ready_o;

  for (genvar p = 0; p < NUM_PROC; p++) begin : g_slot
    assign elig[p]  = proc_ready_i[p] && fit[p];
    assign alloc[p] = disp_valid_o && (pick_idx == PROC_W'(p));
    blkd_smem_slot #(
      .MEM_W(MEM_W), .CAP(SMEM_CAP), .MAX_RES(MAX_RES), .RES_W(RES_W)
    ) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .alloc_i(alloc[p]),
      .done_i (blk_done_i[p]),
      .req_i  (smem_q),
      .fit_o  (fit[p]),
      .rel_o  (rel[p])
    );
  end

  blkd_rr_pick #(.N(NUM_PROC), .IDX_W(PROC_W)) u_pick (
    .ptr_i  (ptr_q),
    .elig_i (elig),
    .valid_o(pick_v),
    .idx_o  (pick_idx)
  );

  assign disp_valid_o  = (state_q == ST_RUN) && (left_q != '0) && pick_v;
  assign disp_blk_id_o = next_id_q;
  assign disp_proc_o   = pick_idx;
  assign grid_done_o   = done_q;

  // last block may be partial: remaining threads saturate at zero
  assign left_step = (left_q > THREAD_W'(blk_thr_q)) ? (left_q - THREAD_W'(blk_thr_q)) : '0;
  assign left_d    = disp_valid_o ? left_step : left_q;

  always_comb begin
    nrel = '0;
    for (int p = 0; p < NUM_PROC; p++) nrel = nrel + OUT_W'(rel[p]);
  end
  assign out_d  = out_q + OUT_W'(disp_valid_o) - nrel;
  assign finish = (state_q == ST_RUN) && (left_d == '0) && (out_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      left_q    <= '0;
      blk_thr_q <= '0;
      smem_q    <= '0;
      next_id_q <= '0;
      out_q     <= '0;
      ptr_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      out_q  <= out_d;
      if (accept) begin
        state_q   <= ST_RUN;
        left_q    <= grid_threads_i;
        blk_thr_q <= grid_blk_thr_i;
        smem_q    <= grid_smem_i;
        next_id_q <= '0;
      end else if (state_q == ST_RUN) begin
        left_q <= left_d;
        if (disp_valid_o) next_id_q <= next_id_q + 1'b1;
        if (finish) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
      if (disp_valid_o)
        ptr_q <= (pick_idx == PROC_W'(NUM_PROC - 1)) ? '0 : pick_idx + 1'b1;
    end
  end

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grid_valid_i && grid_ready_o) |=> !grid_ready_o);
  a_r3_id_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(disp_valid_o) && disp_valid_o) |-> (disp_blk_id_o == $past(disp_blk_id_o) + 1'b1));
  a_r5_ready_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> proc_ready_i[disp_proc_o]);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grid_done_o |=> !grid_done_o);
  a_r9_idle_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grid_done_o |-> (grid_ready_o && !disp_valid_o));
endmodule

// File: tb/block_dispatcher_tb.sv
module block_dispatcher_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        grid_valid_i = 1'b0;
  logic        grid_ready_o;
  logic [15:0] grid_threads_i = '0;
  logic [10:0] grid_blk_thr_i = '0;
  logic [19:0] grid_smem_i = '0;
  logic [3:0]  proc_ready_i = '1;
  logic [3:0]  blk_done_i = '0;
  logic        disp_valid_o;
  logic [15:0] disp_blk_id_o;
  logic [1:0]  disp_proc_o;
  logic        grid_done_o;

  int n_chk = 0;
  int n_fail = 0;
  int res[NP];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  block_dispatcher u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .grid_valid_i(grid_valid_i), .grid_ready_o(grid_ready_o),
    .grid_threads_i(grid_threads_i), .grid_blk_thr_i(grid_blk_thr_i),
    .grid_smem_i(grid_smem_i), .proc_ready_i(proc_ready_i),
    .blk_done_i(blk_done_i), .disp_valid_o(disp_valid_o),
    .disp_blk_id_o(disp_blk_id_o), .disp_proc_o(disp_proc_o),
    .grid_done_o(grid_done_o)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(string req, string what, int act, int exp);
    check(act == exp, req, what, act, exp);
  endtask

  // one cycle slot: drive done mask, check dispatch, advance to next negedge
  task automatic slot(logic [3:0] dm, bit ev, int eid, int ep, string req);
    blk_done_i = dm;
    #1;
    chk_eq(req, "disp_valid", int'(disp_valid_o), int'(ev));
    if (ev) begin
      chk_eq(req, "block id", int'(disp_blk_id_o), eid);
      chk_eq(req, "target proc", int'(disp_proc_o), ep);
      res[ep]++;
    end
    for (int p = 0; p < NP; p++) if (dm[p] && res[p] > 0) res[p]--;
    @(negedge clk_i);
    blk_done_i = '0;
  endtask

  task automatic start_grid(int thr, int bt, int sm);
    grid_valid_i   = 1'b1;
    grid_threads_i = 16'(thr);
    grid_blk_thr_i = 11'(bt);
    grid_smem_i    = 20'(sm);
    #1;
    chk_eq("R2", "ready while idle", int'(grid_ready_o), 1);
    @(negedge clk_i);
    grid_valid_i = 1'b0;
  endtask

  // retire every resident block, one per cycle; done must follow the last one
  task automatic drain(string req);
    int total = 0;
    for (int p = 0; p < NP; p++) total += res[p];
    for (int p = 0; p < NP; p++) begin
      while (res[p] > 0) begin
        #1;
        chk_eq("R9", "grid_done before last retire", int'(grid_done_o), 0);
        slot(4'(1 << p), 1'b0, 0, 0, req);
      end
    end
    #1;
    chk_eq("R9", "grid_done after last retire", int'(grid_done_o), 1);
    chk_eq("R9", "ready with done", int'(grid_ready_o), 1);
    @(negedge clk_i);
    #1;
    chk_eq("R9", "grid_done single pulse", int'(grid_done_o), 0);
  endtask

  task automatic t_reset();
    #1;
    chk_eq("R1", "grid_ready_o", int'(grid_ready_o), 1);
    chk_eq("R1", "disp_valid_o", int'(disp_valid_o), 0);
    chk_eq("R1", "grid_done_o", int'(grid_done_o), 0);
    @(negedge clk_i);
  endtask

  // R3 R4: exact multiple, round-robin from pointer 0
  task automatic t_basic();
    start_grid(8192, 512, 1024);
    for (int k = 0; k < 16; k++) slot(4'b0, 1'b1, k, k % NP, "R3/R4");
    slot(4'b0, 1'b0, 0, 0, "R3 no extra block");
    drain("R9");
  endtask

  // R3 rounding up, R2 descriptor ignored while busy
  task automatic t_round_busy();
    start_grid(1000, 256, 64);
    grid_valid_i   = 1'b1;
    grid_threads_i = 16'd4000;
    grid_blk_thr_i = 11'd100;
    #1;
    chk_eq("R2", "ready while running", int'(grid_ready_o), 0);
    for (int k = 0; k < 4; k++) slot(4'b0, 1'b1, k, k, "R3 ceil / R2");
    slot(4'b0, 1'b0, 0, 0, "R2 block count kept");
    grid_valid_i = 1'b0;
    drain("R9");
  endtask

  // R6 capacity stall, R8 release reuse, R10 same-cycle alloc+release
  task automatic t_smem();
    start_grid(704, 64, 200000);
    for (int k = 0; k < 8; k++) slot(4'b0, 1'b1, k, k % NP, "R6 fill");
    slot(4'b0, 1'b0, 0, 0, "R6 stall when pools full");
    slot(4'b0100, 1'b0, 0, 0, "R8 release");
    slot(4'b0, 1'b1, 8, 2, "R8 reuse next cycle");
    slot(4'b0010, 1'b0, 0, 0, "R8 release");
    slot(4'b0010, 1'b1, 9, 1, "R10 alloc with release");
    slot(4'b0, 1'b1, 10, 1, "R10 both updates applied");
    slot(4'b0, 1'b0, 0, 0, "R3 grid exhausted");
    drain("R9");
  endtask

  // R5 ready gating, R7 resident limit, R8 stray pulse
  task automatic t_limit();
    proc_ready_i = 4'b1010;
    start_grid(1152, 32, 16);
    for (int k = 0; k < 16; k++) slot(4'b0, 1'b1, k, (k % 2 == 0) ? 3 : 1, "R5 ready mask");
    slot(4'b0, 1'b0, 0, 0, "R7 limit on ready procs");
    slot(4'b0001, 1'b0, 0, 0, "R8 stray pulse");
    proc_ready_i = 4'b1111;
    for (int k = 0; k < 16; k++) slot(4'b0, 1'b1, 16 + k, (k % 2 == 0) ? 2 : 0, "R4/R5 remaining procs");
    slot(4'b0, 1'b0, 0, 0, "R7 all at limit");
    for (int k = 0; k < 4; k++) begin
      slot(4'b0001, 1'b0, 0, 0, "R7 release one");
      slot(4'b0, 1'b1, 32 + k, 0, "R7 refill");
    end
    slot(4'b0, 1'b0, 0, 0, "R3 grid exhausted");
    drain("R8/R9 stray not counted");
  endtask

  initial begin
    for (int p = 0; p < NP; p++) res[p] = 0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_round_busy();
    t_smem();
    t_limit();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule